// File: doc/BRIEF.md
# Indexed Register Window for an Interrupt Routing Table

This block is a 32-bit slave on a single-cycle strobe bus. It exposes two locations: an index register and a data window. Software first writes the index of an internal register, then reads or writes that register through the window.

Behind the window there are:
- an 8-bit identification field;
- a fixed version word;
- an arbitration word that always reads as zero;
- a table of 64-bit routing entries, each reached as two 32-bit halves.

The whole routing table is presented on a flat output bus for the interrupt dispatcher. A one-cycle update strobe tells the dispatcher to rescan its pending requests after any entry half is written. Only the low eight address bits are decoded.

Read data is registered. A small response state machine has two states:
- RW_IDLE: no read data is pending.
- RW_RESP: the read data output holds data captured on the previous clock.

Its transitions are:
- RW_IDLE goes to RW_RESP on a read strobe.
- RW_RESP stays in RW_RESP while read strobes continue back to back.
- RW_RESP goes back to RW_IDLE when a cycle has no read strobe.
- Reset forces RW_IDLE.

Top module: `rw_indirect_window`

## Requirements
- R1: Only address bits 7:0 are decoded; offset 0x00 is the index register and offset 0x10 is the data window. Reads at any other offset return 0, and writes there change nothing.
- R2: Reading offset 0x00 returns the current 8-bit index, zero-extended. Writing it loads wdata[7:0] into the index and changes no other state.
- R3: Window index 0x00 is the identification field, kept in bits 31:24 for both reads and writes; the other read bits are 0.
- R4: Window index 0x01 reads as 0x00170011: version 0x11 in bits 7:0 and the highest entry number (NUM_ENTRIES-1 = 23) in bits 23:16. Writes to it are ignored.
- R5: Window indices 0x02 through 0x0F read as 0, and writes to them are ignored.
- R6: Window index 0x10+2n reaches bits 31:0 of entry n and index 0x11+2n reaches bits 63:32. A write to one half leaves the other half unchanged.
- R7: Window indices at or above 0x10+2*NUM_ENTRIES (0x40) read as 0, and writes to them are ignored.
- R8: Reset clears the index and the ID, and sets every entry to 0x0000_0000_0001_0000 (only the mask bit 16 set).
- R9: `upd_o` is high for exactly the one cycle after each write to an entry half, and low after every other kind of cycle.
- R10: `rvalid_o` is high in the cycle after each read strobe, and `rdata_o` then holds the value that existed when the strobe was sampled.
- R11: Entry n appears on `route_o[64n+63:64n]`, and the new value is visible in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 32 | Bus address; only bits 7:0 are decoded |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |
| route_o | output | 1536 | Flat routing table, entry n at bits 64n+63:64n |
| upd_o | output | 1 | One-cycle rescan strobe after an entry-half write |

## Verification
A wrong index register misroutes every later window access. It shows on `rdata_o` at the next read, and on `route_o` one cycle after the next window write. A corrupted entry, or a half write that spills into the other half, is visible on `route_o` in the cycle after the write, so the bench compares the whole bus against its model on every clock. A response state that fails to track the strobe shows up as `rvalid_o` disagreeing with the previous cycle's `rd_i`. A misfiring rescan strobe shows up as `upd_o` disagreeing with the previous cycle's write.

// File: rtl/rw_window_pkg.sv
package rw_window_pkg;
    typedef enum logic {RW_IDLE, RW_RESP} rw_state_e;

    localparam logic [7:0] OFS_INDEX  = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam int         IDX_ID     = 0;
    localparam int         IDX_VER    = 1;
    localparam int         IDX_TAB    = 16;
    localparam logic [7:0] VERSION    = 8'h11;
    localparam int         MASK_BIT   = 16;
endpackage

// File: rtl/rw_access_fsm.sv
module rw_access_fsm
    import rw_window_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    output logic rvalid_o
);
    rw_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RW_IDLE: if (rd_i)  state_d = RW_RESP;
            RW_RESP: if (!rd_i) state_d = RW_IDLE;
            default:            state_d = RW_IDLE;
        endcase
    end

    always_comb begin
        rvalid_o = (state_q == RW_RESP);
    end
endmodule

// File: rtl/rw_idx_decode.sv
module rw_idx_decode
    import rw_window_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    parameter int IDX_W       = 8,
    localparam int ENT_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             is_id_o,
    output logic             is_ver_o,
    output logic             is_ent_o,
    output logic [ENT_W-1:0] ent_o,
    output logic             hi_o
);
    localparam int TAB_END = IDX_TAB + 2 * NUM_ENTRIES;

    logic [IDX_W-1:0] rel;

    always_comb begin
        rel      = idx_i - IDX_W'(IDX_TAB);
        is_id_o  = (idx_i == IDX_W'(IDX_ID));
        is_ver_o = (idx_i == IDX_W'(IDX_VER));
        is_ent_o = (int'(idx_i) >= IDX_TAB) && (int'(idx_i) < TAB_END);
        hi_o     = rel[0];
        ent_o    = ENT_W'(rel >> 1);
    end
endmodule

// File: rtl/rw_route_table.sv
module rw_route_table
    import rw_window_pkg::*;
#(
    parameter int NUM_ENTRIES = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_ENTRIES-1:0]    wr_lo_i,
    input  logic [NUM_ENTRIES-1:0]    wr_hi_i,
    input  logic [31:0]               wdata_i,
    output logic [64*NUM_ENTRIES-1:0] table_o
);
    localparam logic [63:0] ENT_RESET = 64'(1) << MASK_BIT;

    for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
        logic [63:0] ent_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= ENT_RESET;
            end else begin
                if (wr_lo_i[n]) ent_q[31:0]  <= wdata_i;
                if (wr_hi_i[n]) ent_q[63:32] <= wdata_i;
            end
        end

        assign table_o[64*n +: 64] = ent_q;
    end
endmodule

// File: rtl/rw_indirect_window.sv
module rw_indirect_window
    import rw_window_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_ENTRIES = 24,
    parameter int IDX_W       = 8,
    localparam int ENT_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int ROUTE_W    = 64 * NUM_ENTRIES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               rvalid_o,
    output logic [ROUTE_W-1:0] route_o,
    output logic               upd_o
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

    logic [IDX_W-1:0]       idx_q;
    logic [7:0]             id_q;
    logic [31:0]            rdata_q;
    logic                   upd_q;
    logic                   sel_idx, sel_win;
    logic                   is_id, is_ver, is_ent, hi;
    logic [ENT_W-1:0]       ent;
    logic [NUM_ENTRIES-1:0] wr_lo, wr_hi;
    logic [63:0]            ent_arr [NUM_ENTRIES];
    logic [31:0]            rd_mux;
    logic                   ent_wr;

    assign sel_idx = (addr_i[7:0] == OFS_INDEX);
    assign sel_win = (addr_i[7:0] == OFS_WINDOW);
    assign ent_wr  = wr_i && sel_win && is_ent;

    rw_idx_decode #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dec (
        .idx_i    (idx_q),
        .is_id_o  (is_id),
        .is_ver_o (is_ver),
        .is_ent_o (is_ent),
        .ent_o    (ent),
        .hi_o     (hi)
    );

    for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_sel
        assign wr_lo[n]   = ent_wr && (ent == ENT_W'(n)) && !hi;
        assign wr_hi[n]   = ent_wr && (ent == ENT_W'(n)) && hi;
        assign ent_arr[n] = route_o[64*n +: 64];
    end

    rw_route_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wdata_i (wdata_i),
        .table_o (route_o)
    );

    rw_access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_i),
        .rvalid_o (rvalid_o)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_idx) begin
            rd_mux = 32'(idx_q);
        end else if (sel_win) begin
            if (is_id)       rd_mux = {id_q, 24'h0};
            else if (is_ver) rd_mux = VER_WORD;
            else if (is_ent) rd_mux = hi ? ent_arr[ent][63:32] : ent_arr[ent][31:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            id_q    <= '0;
            rdata_q <= '0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= ent_wr;
            if (rd_i) rdata_q <= rd_mux;
            if (wr_i && sel_idx) idx_q <= wdata_i[IDX_W-1:0];
            if (wr_i && sel_win && is_id) id_q <= wdata_i[31:24];
        end
    end

    assign rdata_o = rdata_q;
    assign upd_o   = upd_q;
endmodule

// File: rtl/rw_window_chk.sv
module rw_window_chk #(
    parameter int ADDR_W      = 32,
    parameter int NUM_ENTRIES = 24,
    parameter int IDX_W       = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr_i,
    input logic                      wr_i,
    input logic                      rd_i,
    input logic [31:0]               rdata_o,
    input logic                      rvalid_o,
    input logic [64*NUM_ENTRIES-1:0] route_o,
    input logic                      upd_o,
    input logic [IDX_W-1:0]          idx
);
    localparam int TAB_END = 16 + 2 * NUM_ENTRIES;

    // R9
    upd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(wr_i && addr_i[7:0] == 8'h10));

    // R10
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rvalid_o);

    // R10
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rvalid_o);

    // R6
    route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i[7:0] == 8'h10) |=> $stable(route_o));

    // R1
    stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i[7:0] != 8'h00 && addr_i[7:0] != 8'h10) |=> (rdata_o == 32'h0));

    // R4
    version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i[7:0] == 8'h10 && idx == IDX_W'(1))
        |=> (rdata_o == {8'h00, 8'(NUM_ENTRIES - 1), 16'h0011}));

    // R7
    beyond_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i[7:0] == 8'h10 && int'(idx) >= TAB_END) |=> (rdata_o == 32'h0));
endmodule

bind rw_indirect_window rw_window_chk #(
    .ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .route_o  (route_o),
    .upd_o    (upd_o),
    .idx      (idx_q)
);

// File: tb/sim_rw_indirect_window.sv
module sim_rw_indirect_window;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   addr = '0;
    logic          wr = 1'b0, rd = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid;
    logic [64*NE-1:0] route;
    logic          upd;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic [7:0]  m_idx;
    logic [7:0]  m_id;
    logic [63:0] m_tab [NE];
    logic [31:0] m_rdata;
    logic        m_rvalid;
    logic        m_upd;
    string       m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    rw_indirect_window u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .route_o(route), .upd_o(upd)
    );

    function automatic logic [31:0] model_read(input logic [7:0] ofs);
        if (ofs == 8'h00) return {24'h0, m_idx};
        if (ofs != 8'h10) return 32'h0;
        if (m_idx == 8'h00) return {m_id, 24'h0};
        if (m_idx == 8'h01) return 32'h0017_0011;
        if (m_idx >= 8'h10 && m_idx < 8'h40) begin
            if (m_idx[0]) return m_tab[(m_idx - 8'h10) / 2][63:32];
            return m_tab[(m_idx - 8'h10) / 2][31:0];
        end
        return 32'h0;
    endfunction

    function automatic string tag_of(input logic [7:0] ofs);
        if (ofs == 8'h00) return "R2";
        if (ofs != 8'h10) return "R1";
        if (m_idx == 8'h00) return "R3";
        if (m_idx == 8'h01) return "R4";
        if (m_idx < 8'h10) return "R5";
        if (m_idx < 8'h40) return "R6";
        return "R7";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_id = 0; m_rdata = 0; m_rvalid = 0; m_upd = 0; m_tag = "R8";
            for (int i = 0; i < NE; i++) m_tab[i] = 64'h0000_0000_0001_0000;
        end else begin
            m_rvalid = rd;
            if (rd) begin
                m_rdata = model_read(addr[7:0]);
                m_tag = tag_of(addr[7:0]);
            end
            m_upd = 0;
            if (wr && addr[7:0] == 8'h00) begin
                m_idx = wdata[7:0];
            end else if (wr && addr[7:0] == 8'h10) begin
                if (m_idx == 8'h00) m_id = wdata[31:24];
                else if (m_idx >= 8'h10 && m_idx < 8'h40) begin
                    m_upd = 1;
                    if (m_idx[0]) m_tab[(m_idx - 8'h10) / 2][63:32] = wdata;
                    else          m_tab[(m_idx - 8'h10) / 2][31:0]  = wdata;
                end
            end
        end
    end

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check32("R10 rvalid", {31'h0, rvalid}, {31'h0, m_rvalid});
            check32("R9 upd", {31'h0, upd}, {31'h0, m_upd});
            begin
                bit ok = 1;
                for (int i = 0; i < NE; i++)
                    if (route[64*i +: 64] !== m_tab[i]) ok = 0;
                checks++;
                if (!ok) begin
                    errors++;
                    for (int i = 0; i < NE; i++)
                        if (route[64*i +: 64] !== m_tab[i]) begin
                            $display("FAIL R11 route entry %0d: actual=%h expected=%h",
                                     i, route[64*i +: 64], m_tab[i]);
                            break;
                        end
                end
            end
            if (m_rvalid) check32({m_tag, " rdata"}, rdata, m_rdata);
        end
    end

    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1; rd = 0;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic bus_rd(input logic [31:0] a);
        @(negedge clk);
        addr = a; rd = 1; wr = 0;
        @(negedge clk);
        rd = 0;
    endtask

    task automatic win_wr(input logic [7:0] ix, input logic [31:0] d);
        bus_wr(32'h0, {24'h0, ix});
        bus_wr(32'h10, d);
    endtask

    task automatic win_rd(input logic [7:0] ix);
        bus_wr(32'h0, {24'h0, ix});
        bus_rd(32'h10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state on the outputs, before any bus traffic
        check32("R8 rvalid", {31'h0, rvalid}, 32'h0);
        check32("R8 upd", {31'h0, upd}, 32'h0);
        check32("R8 entry0", route[31:0], 32'h0001_0000);
        check32("R8 entry23 hi", route[64*23+32 +: 32], 32'h0);
        rst_n = 1;
        bus_rd(32'h0);           // R8 index 0
        win_rd(8'h00);           // R8 id 0
        win_rd(8'h11);           // R8 entry hi
        // R3
        win_wr(8'h00, 32'hAB12_3456);
        win_rd(8'h00);
        // R4
        win_rd(8'h01);
        win_wr(8'h01, 32'hFFFF_FFFF);
        win_rd(8'h01);
        // R5
        win_wr(8'h02, 32'h5555_AAAA);
        win_rd(8'h02);
        win_wr(8'h07, 32'h1234_5678);
        win_rd(8'h07);
        // R6
        win_wr(8'h10, 32'h1234_5678);
        win_wr(8'h11, 32'hCAFE_F00D);
        win_rd(8'h10);
        win_rd(8'h11);
        win_wr(8'h3F, 32'hDEAD_BEEF);
        win_wr(8'h10, 32'h0000_0001);
        win_rd(8'h11);
        win_rd(8'h3E);
        // R7
        win_wr(8'h40, 32'hFFFF_FFFF);
        win_rd(8'h40);
        win_wr(8'hFF, 32'hFFFF_FFFF);
        win_rd(8'hFF);
        // R1: stray offsets and high address bits
        bus_wr(32'h0, 32'h0000_0012);
        bus_wr(32'h0000_0020, 32'hFFFF_FFFF);
        bus_rd(32'h0000_0004);
        bus_wr(32'hFEC0_0010, 32'h7777_0000);
        bus_rd(32'hFEC0_0010);
        bus_rd(32'hFEC0_0000);
        // R2: only low 8 bits of the index load
        bus_wr(32'h0, 32'hFFFF_1234);
        bus_rd(32'h0);
        // R10: back-to-back reads
        bus_wr(32'h0, 32'h0000_0013);
        @(negedge clk);
        addr = 32'h10; rd = 1;
        @(negedge clk);
        addr = 32'h0;
        @(negedge clk);
        addr = 32'h3;
        @(negedge clk);
        rd = 0;
        // mixed pseudo-random traffic
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            @(negedge clk);
            wr = r[0];
            rd = r[1];
            case (r[3:2])
                2'd0: addr = 32'h0;
                2'd1, 2'd2: addr = 32'h10;
                default: addr = {24'h0, r[11:4]};
            endcase
            wdata = (addr[7:0] == 8'h00) ? {24'h0, 2'b00, r[17:12]} : $urandom;
        end
        @(negedge clk);
        wr = 0; rd = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule